// File: doc/BRIEF.md
# Serializer Lane Mode and Power Sequencer

This controller sits beside a parallel-to-serial video link transmitter that has two output banks (A and B), each with a group of data lanes and one clock lane. From three static configuration inputs, a two-bit pixel mode, a colour-depth select and an active-high enable, it picks the data path. The three paths are one pixel in to one bank, one pixel in split across two banks, and two pixels in to two banks. It also assigns every lane of both banks one of three drive states: active, high-impedance or powered down (pulled low).

The controller runs on a free reference clock. It watches the pixel clock through a synchronizer and treats the pixel clock as lost when no pixel-clock edge is seen for a set number of reference cycles. When the enable rises, and again whenever the pixel clock comes back, it holds every lane powered down for a lock-wait interval counted in reference cycles. Only then does it declare the link up. The reserved mode code shuts the link down and raises an error flag. Power-down of an unused bank or lane always takes priority over high-impedance, so an unused lane is never left floating.

Top module: `ser_mode_power_ctl`

## Requirements
- R1: `path_sel` reports the active data path while the link is up: mode 2'b00 gives code 0 (single in, single out), 2'b01 gives code 1 (single in, split to two banks), 2'b10 gives code 2 (dual in, dual out). While the link is down it reads code 3.
- R2: One reference cycle after `pwr_en` is sampled low, and from reset, every lane of both banks reads code 2'b00 (powered down). Both `bank_clk_en` bits are 0 and `link_up` is 0.
- R3: While the link is up with `depth18` low, every lane of each bank in use reads 2'b01 (active). Lane i occupies bits [2i+1:2i] of `lane_a`/`lane_b`. Bank A is always in use and drives `bank_clk_en[0]`.
- R4: While the link is up with `depth18` high, the top lane (index LANES-1) of each bank in use reads 2'b10 (high-impedance) and its other lanes read 2'b01.
- R5: In mode 2'b00, bank B is unused. All of its lanes read 2'b00, even when `depth18` is high, and `bank_clk_en[1]` is 0. In modes 2'b01 and 2'b10, `bank_clk_en[1]` follows `link_up`.
- R6: With the pixel clock running, `link_up` is still 0 LOCK_CYCLES reference edges after `pwr_en` is first sampled high and is 1 one edge later. All lanes read 2'b00 during the wait.
- R7: One cycle after mode 2'b11 is sampled, `mode_err` is 1 and the link is down with all lanes powered down. One cycle after a valid mode returns, `mode_err` is 0, and the link comes back through the full lock wait of R6.
- R8: When the pixel clock stops for LOSS_CYCLES reference cycles or more, `clk_lost` goes to 1 within LOSS_CYCLES+8 cycles of the last pixel-clock edge. The link drops and all lanes read 2'b00. A gap of LOSS_CYCLES/2 cycles does not drop the link.
- R9: When the pixel clock returns, `clk_lost` falls while `link_up` stays 0. The link comes up only after a new lock wait.
- R10: If `pwr_en` is raised while no pixel clock is present, `clk_lost` goes to 1 one cycle later and the link stays down. While `pwr_en` is low, `clk_lost` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Pixel mode: 00 single/single, 01 single/split, 10 dual/dual, 11 reserved |
| depth18 | input | 1 | High: reduced colour depth, top lane of each used bank high-impedance |
| pwr_en | input | 1 | High: operate; low: sleep |
| pix_clk | input | 1 | Pixel clock, observed asynchronously for activity |
| lane_a | output | 2*LANES | Bank A lane states, 2 bits per lane (00 down, 01 active, 10 high-Z) |
| lane_b | output | 2*LANES | Bank B lane states, same encoding |
| bank_clk_en | output | 2 | Clock-lane enables, bit 0 bank A, bit 1 bank B |
| path_sel | output | 2 | Data path code (0 single, 1 split, 2 dual, 3 off) |
| link_up | output | 1 | Lock wait complete, lanes driven |
| clk_lost | output | 1 | Enabled but pixel clock absent |
| mode_err | output | 1 | Reserved mode code present |

## Verification
A sequencer stuck in the wrong state shows at the ports within one reference cycle, because lane codes, clock enables and the path code all derive from it. Such a fault appears as lanes driven during sleep or during the lock wait, or as lanes held low while `link_up` is 1. A lock counter that is off by one moves the rise of `link_up` by a cycle, and the bench measures that rise exactly from the enable edge. A wrong activity count shows as `clk_lost` rising too early on a short gap or too late on a stop. It also shows as the link returning without a full lock wait after the pixel clock comes back.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;

    typedef enum logic [1:0] {
        LN_DOWN = 2'b00,
        LN_ON   = 2'b01,
        LN_HIZ  = 2'b10
    } lane_e;

    typedef enum logic [1:0] {
        PATH_SINGLE = 2'b00,
        PATH_SPLIT  = 2'b01,
        PATH_DUAL   = 2'b10,
        PATH_OFF    = 2'b11
    } path_e;

    typedef enum logic [1:0] {
        ST_SLEEP = 2'b00,
        ST_LOCK  = 2'b01,
        ST_RUN   = 2'b10,
        ST_STALL = 2'b11
    } seq_e;

endpackage

// File: rtl/ser_cfg_decode.sv
module ser_cfg_decode
    import ser_ctl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [1:0]         mode_sel,
    input  logic               depth18,
    output logic               cfg_ok,
    output logic               b_used,
    output path_e              path,
    output logic [2*LANES-1:0] lane_a_run,
    output logic [2*LANES-1:0] lane_b_run
);

    always_comb begin
        cfg_ok = 1'b1;
        b_used = 1'b0;
        path   = PATH_OFF;
        case (mode_sel)
            2'b00: path = PATH_SINGLE;
            2'b01: begin
                path   = PATH_SPLIT;
                b_used = 1'b1;
            end
            2'b10: begin
                path   = PATH_DUAL;
                b_used = 1'b1;
            end
            default: cfg_ok = 1'b0;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam bit IS_TOP = (i == LANES - 1);
        lane_e lane_run;
        always_comb begin
            lane_run = (IS_TOP && depth18) ? LN_HIZ : LN_ON;
        end
        assign lane_a_run[2*i +: 2] = lane_run;
        assign lane_b_run[2*i +: 2] = b_used ? lane_run : LN_DOWN;
    end

endmodule

// File: rtl/ser_clk_monitor.sv
module ser_clk_monitor #(
    parameter int LOSS_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_clk,
    output logic clk_ok
);

    localparam int IW = $clog2(LOSS_CYCLES + 1);
    localparam logic [IW-1:0] IDLE_MAX = IW'(LOSS_CYCLES);

    typedef struct packed {
        logic [2:0]    sync;
        logic [IW-1:0] idle;
    } mon_t;

    mon_t mon_d, mon_q;
    logic pix_edge;

    always_comb begin
        mon_d      = mon_q;
        mon_d.sync = {mon_q.sync[1:0], pix_clk};
        pix_edge   = mon_q.sync[2] ^ mon_q.sync[1];
        if (pix_edge) begin
            mon_d.idle = '0;
        end else if (mon_q.idle != IDLE_MAX) begin
            mon_d.idle = mon_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q.sync <= '0;
            mon_q.idle <= IDLE_MAX;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign clk_ok = (mon_q.idle < IDLE_MAX);

endmodule

// File: rtl/ser_lock_seq.sv
module ser_lock_seq
    import ser_ctl_pkg::*;
#(
    parameter int LOCK_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic cfg_ok,
    input  logic clk_ok,
    output seq_e state,
    output logic mode_err
);

    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(LOCK_CYCLES - 1);

    typedef struct packed {
        seq_e          st;
        logic [CW-1:0] cnt;
        logic          err;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.err = !cfg_ok;
        if (!pwr_en || !cfg_ok) begin
            seq_d.st  = ST_SLEEP;
            seq_d.cnt = '0;
        end else begin
            case (seq_q.st)
                ST_SLEEP: begin
                    seq_d.st  = clk_ok ? ST_LOCK : ST_STALL;
                    seq_d.cnt = '0;
                end
                ST_LOCK: begin
                    if (!clk_ok) begin
                        seq_d.st  = ST_STALL;
                        seq_d.cnt = '0;
                    end else if (seq_q.cnt == CNT_LAST) begin
                        seq_d.st = ST_RUN;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!clk_ok) begin
                        seq_d.st = ST_STALL;
                    end
                end
                default: begin
                    if (clk_ok) begin
                        seq_d.st  = ST_LOCK;
                        seq_d.cnt = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= ST_SLEEP;
            seq_q.cnt <= '0;
            seq_q.err <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state    = seq_q.st;
    assign mode_err = seq_q.err;

endmodule

// File: rtl/ser_mode_power_ctl.sv
module ser_mode_power_ctl
    import ser_ctl_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int LOCK_CYCLES = 100000,
    parameter int LOSS_CYCLES = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_sel,
    input  logic               depth18,
    input  logic               pwr_en,
    input  logic               pix_clk,
    output logic [2*LANES-1:0] lane_a,
    output logic [2*LANES-1:0] lane_b,
    output logic [1:0]         bank_clk_en,
    output logic [1:0]         path_sel,
    output logic               link_up,
    output logic               clk_lost,
    output logic               mode_err
);

    logic               cfg_ok;
    logic               b_used;
    path_e              path;
    logic [2*LANES-1:0] lane_a_run;
    logic [2*LANES-1:0] lane_b_run;
    logic               clk_ok;
    seq_e               state;
    logic               run;

    ser_cfg_decode #(.LANES(LANES)) i_decode (
        .mode_sel   (mode_sel),
        .depth18    (depth18),
        .cfg_ok     (cfg_ok),
        .b_used     (b_used),
        .path       (path),
        .lane_a_run (lane_a_run),
        .lane_b_run (lane_b_run)
    );

    ser_clk_monitor #(.LOSS_CYCLES(LOSS_CYCLES)) i_monitor (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_clk (pix_clk),
        .clk_ok  (clk_ok)
    );

    ser_lock_seq #(.LOCK_CYCLES(LOCK_CYCLES)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_en   (pwr_en),
        .cfg_ok   (cfg_ok),
        .clk_ok   (clk_ok),
        .state    (state),
        .mode_err (mode_err)
    );

    always_comb begin
        run         = (state == ST_RUN);
        lane_a      = run ? lane_a_run : '0;
        lane_b      = run ? lane_b_run : '0;
        bank_clk_en = {run & b_used, run};
        path_sel    = run ? path : PATH_OFF;
        link_up     = run;
        clk_lost    = (state == ST_STALL);
    end

endmodule

// File: rtl/ser_mode_power_ctl_chk.sv
module ser_mode_power_ctl_chk #(
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode_sel,
    input logic               pwr_en,
    input logic [2*LANES-1:0] lane_a,
    input logic [2*LANES-1:0] lane_b,
    input logic [1:0]         bank_clk_en,
    input logic [1:0]         path_sel,
    input logic               link_up,
    input logic               clk_lost,
    input logic               mode_err
);

    p_path_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |-> (path_sel == 2'b11));

    p_sleep_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> (lane_a == '0 && lane_b == '0 && bank_clk_en == 2'b00 && !link_up));

    p_low_lane_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> (lane_a[1:0] == 2'b01 && bank_clk_en[0]));

    p_bank_b_unused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && mode_sel == 2'b00) |-> (lane_b == '0 && !bank_clk_en[1]));

    p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |=> (mode_err && !link_up && lane_a == '0));

    p_lost_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_lost |-> (!link_up && lane_a == '0 && lane_b == '0));

    p_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_lost) |-> !link_up);

    p_sleep_no_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> !clk_lost);

endmodule

bind ser_mode_power_ctl ser_mode_power_ctl_chk #(.LANES(LANES)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .pwr_en      (pwr_en),
    .lane_a      (lane_a),
    .lane_b      (lane_b),
    .bank_clk_en (bank_clk_en),
    .path_sel    (path_sel),
    .link_up     (link_up),
    .clk_lost    (clk_lost),
    .mode_err    (mode_err)
);

// File: tb/test_ser_mode_power_ctl.sv
module test_ser_mode_power_ctl;

    localparam int LANES = 4;
    localparam int LOCK  = 20;
    localparam int LOSS  = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         mode_sel = 2'b00;
    logic               depth18 = 1'b0;
    logic               pwr_en = 1'b0;
    logic               pix_clk = 1'b0;
    logic [2*LANES-1:0] lane_a;
    logic [2*LANES-1:0] lane_b;
    logic [1:0]         bank_clk_en;
    logic [1:0]         path_sel;
    logic               link_up;
    logic               clk_lost;
    logic               mode_err;

    int checks = 0;
    int errors = 0;
    logic pix_run = 1'b1;
    int pix_div = 0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (pix_run) begin
            if (pix_div == 2) begin
                pix_div <= 0;
                pix_clk <= ~pix_clk;
            end else begin
                pix_div <= pix_div + 1;
            end
        end
    end

    ser_mode_power_ctl #(
        .LANES(LANES), .LOCK_CYCLES(LOCK), .LOSS_CYCLES(LOSS)
    ) i_ser_mode_power_ctl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .depth18(depth18),
        .pwr_en(pwr_en), .pix_clk(pix_clk), .lane_a(lane_a), .lane_b(lane_b),
        .bank_clk_en(bank_clk_en), .path_sel(path_sel), .link_up(link_up),
        .clk_lost(clk_lost), .mode_err(mode_err)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [2*LANES-1:0] exp_lanes(input bit bank_b, input logic [1:0] m,
                                                      input bit d18, input bit run);
        logic [2*LANES-1:0] v = '0;
        for (int i = 0; i < LANES; i++) begin
            if (run && !(bank_b && m == 2'b00))
                v[2*i +: 2] = (i == LANES - 1 && d18) ? 2'b10 : 2'b01;
        end
        return v;
    endfunction

    task automatic chk_down(input string req);
        chk({req, " lane_a"}, 32'(lane_a), 32'h0);
        chk({req, " lane_b"}, 32'(lane_b), 32'h0);
        chk({req, " clk_en"}, 32'(bank_clk_en), 32'h0);
        chk({req, " link_up"}, 32'(link_up), 32'h0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R2 reset state, R1 path off
        chk_down("R2 reset");
        chk("R1 reset path", 32'(path_sel), 32'd3);
        chk("R10 reset clk_lost", 32'(clk_lost), 32'd0);

        // R2 sleep across every valid mode and depth
        for (int m = 0; m < 3; m++) begin
            for (int d = 0; d < 2; d++) begin
                mode_sel = 2'(m);
                depth18  = d[0];
                step(1);
                chk_down("R2 sleep sweep");
                chk("R1 sleep path", 32'(path_sel), 32'd3);
            end
        end

        // R6 exact lock wait
        mode_sel = 2'b00;
        depth18  = 1'b0;
        pwr_en   = 1'b1;
        step(LOCK);
        chk_down("R6 during wait");
        step(1);
        chk("R6 link rises", 32'(link_up), 32'd1);

        // R1 R3 R4 R5 sweep while running
        for (int m = 0; m < 3; m++) begin
            for (int d = 0; d < 2; d++) begin
                mode_sel = 2'(m);
                depth18  = d[0];
                step(1);
                chk("R1 path", 32'(path_sel), 32'(m));
                chk(d ? "R4 lane_a" : "R3 lane_a", 32'(lane_a),
                    32'(exp_lanes(1'b0, 2'(m), d[0], 1'b1)));
                chk(m == 0 ? "R5 lane_b" : (d ? "R4 lane_b" : "R3 lane_b"), 32'(lane_b),
                    32'(exp_lanes(1'b1, 2'(m), d[0], 1'b1)));
                chk("R5 clk_en", 32'(bank_clk_en), (m == 0) ? 32'd1 : 32'd3);
            end
        end

        // R2 power-down while running, then R6 again
        mode_sel = 2'b10;
        depth18  = 1'b1;
        pwr_en   = 1'b0;
        step(1);
        chk_down("R2 drop");
        pwr_en = 1'b1;
        step(LOCK);
        chk("R6 second wait", 32'(link_up), 32'd0);
        step(1);
        chk("R6 second rise", 32'(link_up), 32'd1);

        // R7 reserved mode
        mode_sel = 2'b11;
        step(1);
        chk("R7 err set", 32'(mode_err), 32'd1);
        chk_down("R7 reserved");
        chk("R7 path", 32'(path_sel), 32'd3);
        mode_sel = 2'b01;
        step(1);
        chk("R7 err clear", 32'(mode_err), 32'd0);
        step(LOCK - 1);
        chk("R7 relock wait", 32'(link_up), 32'd0);
        step(1);
        chk("R7 relock rise", 32'(link_up), 32'd1);

        // R8 clock loss
        pix_run = 1'b0;
        step(LOSS / 2);
        chk("R8 short gap", 32'(link_up), 32'd1);
        step(LOSS + 8 - LOSS / 2);
        chk("R8 lost flag", 32'(clk_lost), 32'd1);
        chk_down("R8 lost");

        // R9 clock return
        pix_run = 1'b1;
        step(8);
        chk("R9 lost clears", 32'(clk_lost), 32'd0);
        chk("R9 still down", 32'(link_up), 32'd0);
        step(LOCK - 8);
        chk("R9 wait honoured", 32'(link_up), 32'd0);
        step(16);
        chk("R9 link back", 32'(link_up), 32'd1);

        // R10 enable without a pixel clock
        pix_run = 1'b0;
        step(LOSS + 8);
        pwr_en = 1'b0;
        step(1);
        chk("R10 sleep clears lost", 32'(clk_lost), 32'd0);
        pwr_en = 1'b1;
        step(1);
        chk("R10 lost on enable", 32'(clk_lost), 32'd1);
        chk_down("R10 enable no clock");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule